// File: doc/BRIEF.md
# Weighted Fair Queueing Tag Scheduler

This block orders packet departures across a small set of flows by virtual finish time. Each arriving packet descriptor carries a flow number and a length. The block gives the packet a start tag: the current system virtual time if its flow holds nothing, or else the finish tag of the packet queued just before it in that flow. It then adds the length divided by the flow's weight, which gives the finish tag. That tag is stored in a small FIFO kept for the flow.

When the downstream link is ready for another packet, it raises a dequeue request. One cycle later the block reports the flow whose head packet has the smallest finish tag, together with that tag, and removes the head packet. The system virtual time then moves to the finish tag just served. Flows with larger weights gain finish time more slowly, so they are picked more often. Payload storage and classification stay outside the block; only tags move through it.

Top module: `wfq_tag_sched`

## Requirements
- R1: After reset, deq_valid and arr_drop are low and virt_time is zero.
- R2: A packet's finish tag is its start tag plus the integer quotient of its length by its flow's weight. The weight for flow f sits in flow_wgt bits [4f+3:4f], and a weight of 0 acts as 1.
- R3: A packet that arrives while its flow holds no packets takes the current virt_time as its start tag.
- R4: A packet that arrives while its flow holds packets takes the finish tag of the last packet accepted into that flow as its start tag.
- R5: On the cycle after a dequeue request, if any flow held a packet, deq_valid is high. deq_flow and deq_tag then give the flow with the smallest head finish tag and that tag, and the packet is removed.
- R6: When head finish tags are equal, the lowest flow number is served.
- R7: Within one flow, packets leave in arrival order.
- R8: Each served packet sets virt_time to the larger of virt_time and the served finish tag, one cycle after the request. virt_time never decreases.
- R9: An arrival to a flow that already holds 8 packets is discarded. arr_drop pulses high on the next cycle, and the contents of the flow are unchanged.
- R10: A dequeue request while all flows are empty gives deq_valid low on the next cycle and leaves virt_time unchanged.
- R11: When an arrival and a dequeue happen in the same cycle, the emptiness test, fullness test and virtual time used for the arrival are those held before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flow_wgt | input | 16 | Per-flow weights, 4 bits per flow |
| arr_valid | input | 1 | Arrival strobe |
| arr_flow | input | 2 | Flow number of the arrival |
| arr_len | input | 12 | Packet length of the arrival |
| arr_drop | output | 1 | Pulse: previous arrival was discarded |
| deq_req | input | 1 | Request the next packet to serve |
| deq_valid | output | 1 | A packet was selected for the previous request |
| deq_flow | output | 2 | Flow of the selected packet |
| deq_tag | output | 24 | Finish tag of the selected packet |
| virt_time | output | 24 | System virtual time |

## Verification
The bench builds the block with its defaults: 4 flows, 8-deep queues, 24-bit tags, 12-bit lengths and 4-bit weights. The weights are set to 1, 2, 4 and 0, so integer division, the weight-0 rule and a tie between different weights can all be reached. Eight entries per flow is shallow enough that the full-queue drop and the drain after it are reached within a few dozen cycles. The 24-bit tag width keeps a long pseudo-random mix of arrivals and requests well clear of wrap-around.

// File: rtl/wfq_tag_sched.sv
module wfq_tag_sched #(
  parameter int NUM_FLOWS = 4,
  parameter int DEPTH     = 8,
  parameter int TAG_W     = 24,
  parameter int LEN_W     = 12,
  parameter int WGT_W     = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_FLOWS*WGT_W-1:0] flow_wgt,
  input  logic                       arr_valid,
  input  logic [$clog2(NUM_FLOWS)-1:0] arr_flow,
  input  logic [LEN_W-1:0]           arr_len,
  output logic                       arr_drop,
  input  logic                       deq_req,
  output logic                       deq_valid,
  output logic [$clog2(NUM_FLOWS)-1:0] deq_flow,
  output logic [TAG_W-1:0]           deq_tag,
  output logic [TAG_W-1:0]           virt_time
);
  localparam int FID_W = $clog2(NUM_FLOWS);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [TAG_W-1:0] tagq     [NUM_FLOWS][DEPTH];
  logic [PTR_W-1:0] rdp      [NUM_FLOWS];
  logic [PTR_W-1:0] wrp      [NUM_FLOWS];
  logic [CNT_W-1:0] cnt      [NUM_FLOWS];
  logic [TAG_W-1:0] last_fin [NUM_FLOWS];

  logic [WGT_W-1:0] cur_w;
  logic [LEN_W-1:0] eff_w, scaled;
  logic [TAG_W-1:0] start_tag, fin_tag;
  logic             arr_empty, arr_full, push;

  assign cur_w     = flow_wgt[arr_flow*WGT_W +: WGT_W];
  assign eff_w     = (cur_w == '0) ? LEN_W'(1) : LEN_W'(cur_w);
  assign scaled    = arr_len / eff_w;
  assign arr_empty = (cnt[arr_flow] == '0);
  assign arr_full  = (cnt[arr_flow] == CNT_W'(DEPTH));
  assign start_tag = arr_empty ? virt_time : last_fin[arr_flow];
  assign fin_tag   = start_tag + TAG_W'(scaled);
  assign push      = arr_valid && !arr_full;

  logic             sel_any;
  logic [FID_W-1:0] sel_id;
  logic [TAG_W-1:0] sel_tag;
  logic             pop;

  always_comb begin
    sel_any = 1'b0;
    sel_id  = '0;
    sel_tag = '0;
    for (int f = 0; f < NUM_FLOWS; f++) begin
      if (cnt[f] != '0 && (!sel_any || tagq[f][rdp[f]] < sel_tag)) begin
        sel_any = 1'b1;
        sel_id  = FID_W'(f);
        sel_tag = tagq[f][rdp[f]];
      end
    end
  end

  assign pop = deq_req && sel_any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int f = 0; f < NUM_FLOWS; f++) begin
        rdp[f]      <= '0;
        wrp[f]      <= '0;
        cnt[f]      <= '0;
        last_fin[f] <= '0;
      end
      arr_drop  <= 1'b0;
      deq_valid <= 1'b0;
      deq_flow  <= '0;
      deq_tag   <= '0;
      virt_time <= '0;
    end else begin
      arr_drop  <= arr_valid && arr_full;
      deq_valid <= pop;
      if (push) begin
        tagq[arr_flow][wrp[arr_flow]] <= fin_tag;
        wrp[arr_flow]                 <= wrp[arr_flow] + 1'b1;
        last_fin[arr_flow]            <= fin_tag;
      end
      for (int f = 0; f < NUM_FLOWS; f++) begin
        if ((push && arr_flow == FID_W'(f)) && !(pop && sel_id == FID_W'(f)))
          cnt[f] <= cnt[f] + 1'b1;
        else if (!(push && arr_flow == FID_W'(f)) && (pop && sel_id == FID_W'(f)))
          cnt[f] <= cnt[f] - 1'b1;
        if (pop && sel_id == FID_W'(f))
          rdp[f] <= rdp[f] + 1'b1;
      end
      if (pop) begin
        deq_flow <= sel_id;
        deq_tag  <= sel_tag;
        if (sel_tag > virt_time) virt_time <= sel_tag;
      end
    end
  end

  a_r8_vt_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> virt_time >= $past(virt_time));

  a_r8_vt_covers_served: assert property (@(posedge clk) disable iff (!rst_n)
    deq_valid |-> virt_time >= deq_tag);

  a_r5_valid_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    deq_valid |-> $past(deq_req));

  a_r10_empty_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (deq_req && !sel_any) |=> !deq_valid);

  a_r10_empty_vt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_any) |=> $stable(virt_time));

  a_r9_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_valid && cnt[arr_flow] == CNT_W'(DEPTH)) |=> arr_drop);

  a_r9_drop_needs_arrival: assert property (@(posedge clk) disable iff (!rst_n)
    arr_drop |-> $past(arr_valid));

endmodule

// File: tb/test_wfq_tag_sched.sv
`timescale 1ns/1ps
module test_wfq_tag_sched;
  localparam int NF = 4, DP = 8, TW = 24, LW = 12, WW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NF*WW-1:0] flow_wgt;
  logic          arr_valid, deq_req, arr_drop, deq_valid;
  logic [1:0]    arr_flow, deq_flow;
  logic [LW-1:0] arr_len;
  logic [TW-1:0] deq_tag, virt_time;

  always #2.5 clk = ~clk;

  wfq_tag_sched i_wfq_tag_sched (
    .clk(clk), .rst_n(rst_n), .flow_wgt(flow_wgt),
    .arr_valid(arr_valid), .arr_flow(arr_flow), .arr_len(arr_len), .arr_drop(arr_drop),
    .deq_req(deq_req), .deq_valid(deq_valid), .deq_flow(deq_flow), .deq_tag(deq_tag),
    .virt_time(virt_time)
  );

  typedef struct {
    bit    is_deq;
    bit    v;
    int    fl;
    int    tg;
    bit    drop;
    int    vt;
    string req;
  } exp_t;

  exp_t exq[$];
  int   n_cmp = 0, n_bad = 0;
  int   mq[NF][$];
  int   lastf[NF];
  int   vt = 0;
  int   wv[NF] = '{1, 2, 4, 0};

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    exp_t e;
    #1;
    while (exq.size() > 0) begin
      e = exq.pop_front();
      chk(e.req, "arr_drop", int'(arr_drop), int'(e.drop));
      chk("R8", "virt_time", int'(virt_time), e.vt);
      if (e.is_deq) begin
        chk(e.req, "deq_valid", int'(deq_valid), int'(e.v));
        if (e.v) begin
          chk(e.req, "deq_flow", int'(deq_flow), e.fl);
          chk(e.req, "deq_tag", int'(deq_tag), e.tg);
        end
      end
    end
  end

  task automatic step(bit av, int af, int al, bit dq, string req);
    exp_t e;
    int w, st, fn, sel, stg;
    bit any;
    @(negedge clk);
    e.req = req; e.is_deq = dq;
    e.drop = av && (mq[af].size() == DP);
    w  = (wv[af] == 0) ? 1 : wv[af];
    st = (mq[af].size() == 0) ? vt : lastf[af];
    fn = st + al / w;
    any = 0; sel = 0; stg = 0;
    for (int f = 0; f < NF; f++)
      if (mq[f].size() > 0 && (!any || mq[f][0] < stg)) begin
        any = 1; sel = f; stg = mq[f][0];
      end
    e.v = dq && any;
    e.fl = sel; e.tg = stg;
    if (e.v) begin
      void'(mq[sel].pop_front());
      if (stg > vt) vt = stg;
    end
    if (av && !e.drop) begin
      mq[af].push_back(fn);
      lastf[af] = fn;
    end
    e.vt = vt;
    arr_valid = av; arr_flow = 2'(af); arr_len = LW'(al); deq_req = dq;
    exq.push_back(e);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    bit [31:0] r;
    flow_wgt = {4'd0, 4'd4, 4'd2, 4'd1};
    rst_n = 1'b0; arr_valid = 0; arr_flow = 0; arr_len = 0; deq_req = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "deq_valid", int'(deq_valid), 0);
    chk("R1", "arr_drop", int'(arr_drop), 0);
    chk("R1", "virt_time", int'(virt_time), 0);

    step(0, 0, 0, 1, "R10");
    // R2 R3: weights 1,2,4,0 -> fins 100,50,25,30
    step(1, 0, 100, 0, "R3");
    step(1, 1, 100, 0, "R2");
    step(1, 2, 100, 0, "R2");
    step(1, 3, 30, 0, "R2");
    repeat (4) step(0, 0, 0, 1, "R5");
    step(0, 0, 0, 1, "R10");
    // R6: both finish at 140
    step(1, 0, 40, 0, "R3");
    step(1, 1, 80, 0, "R3");
    step(0, 0, 0, 1, "R6");
    step(0, 0, 0, 1, "R6");
    // R4 R7: chained tags in one flow
    step(1, 2, 40, 0, "R4");
    step(1, 2, 41, 0, "R4");
    step(1, 2, 43, 0, "R4");
    repeat (3) step(0, 0, 0, 1, "R7");
    // R9: overflow flow 1
    for (int i = 0; i < DP + 2; i++) step(1, 1, 2 + i, 0, "R9");
    repeat (DP + 1) step(0, 0, 0, 1, "R9");
    // R11: arrival and dequeue in the same cycle
    step(1, 0, 10, 0, "R11");
    step(1, 0, 20, 1, "R11");
    step(1, 0, 30, 1, "R11");
    step(0, 0, 0, 1, "R11");
    // mixed traffic
    r = 32'h1234_5678;
    for (int i = 0; i < 300; i++) begin
      int af, al;
      bit av, dq;
      r = r * 32'd1103515245 + 32'd12345;
      av = r[20]; af = int'(r[17:16]); al = int'(r[29:21]) * 3;
      dq = r[25] | r[26];
      step(av, af, al, dq, "R5");
    end
    repeat (40) step(0, 0, 0, 1, "R5");
    step(0, 0, 0, 0, "R10");
    @(negedge clk);
    @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule